// File: doc/BRIEF.md
# Deferred Exception Token Tracker

This block keeps a one-bit poison token beside each entry of a small register file so that faults from loads hoisted above a guarding branch can be deferred. It sees one instruction descriptor per cycle: an opcode class, two source indices, a destination index, a fault flag and a data word. A speculative load that faults does not raise an exception. It marks its destination instead. Any instruction that reads a marked register produces a marked result, and any fault of its own is dropped.

A consumer may read the speculatively loaded value before any check runs. A single check instruction placed on the last value of a dependence chain therefore covers a fault anywhere earlier in that chain. A check on a clean register does nothing. A check on a marked register raises a one-cycle redirect carrying the recovery address that came with the check. Data words are not examined. They are passed to a registered write-back port together with the token computed for them.

Opcode encoding on `op_i`: 0 = idle, 1 = ALU, 2 = load, 3 = speculative load, 4 = check. Codes 5 to 7 behave as idle. Every output is registered, so the effect of an instruction presented in cycle N appears after the clock edge that ends cycle N.

Top module: `deferred_poison_tracker`

## Requirements
- R1: While `rst_ni` is low and after it is released, all tokens read 0 and `exc_o`, `redir_o`, `wr_en_o` read 0.
- R2: A speculative load (op 3) with `fault_i`=1 marks its destination and never raises `exc_o`.
- R3: A speculative load with `fault_i`=0 and clean sources clears the token of its destination and writes it back clean.
- R4: An ALU, load or speculative load with at least one marked source (one or both) marks its destination, does not raise `exc_o` even when `fault_i`=1, and writes back with `wr_poison_o`=1.
- R5: An ALU op or load with clean sources and `fault_i`=0 clears its destination token. With `fault_i`=1 it raises `exc_o` for one cycle, performs no write, and leaves the destination token unchanged.
- R6: A check (op 4) whose `rs1_i` register is clean raises no redirect and changes no token.
- R7: A check whose `rs1_i` register is marked sets `redir_o` for exactly the following cycle, with `redir_tgt_o` equal to that check's `tgt_i`. `redir_tgt_o` is 0 whenever `redir_o` is 0.
- R8: Register 0 is never marked, and a write-back to register 0 always carries `wr_poison_o`=0.
- R9: Every write-back shows `wr_en_o`=1 with the destination index, the instruction's `data_i` and the new token, one cycle after the instruction.
- R10: When `use_rs2_i`=0, the token of register `rs2_i` has no effect on the result.
- R11: A descriptor with `valid_i`=0, or with op 0 or 5 to 7, changes no token and raises no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Descriptor present this cycle |
| op_i | input | 3 | Opcode class |
| rs1_i | input | IDX_W (4) | First source index, also the register tested by a check |
| rs2_i | input | IDX_W (4) | Second source index |
| use_rs2_i | input | 1 | Second source is read |
| rd_i | input | IDX_W (4) | Destination index |
| fault_i | input | 1 | The instruction faulted |
| data_i | input | DATA_W (32) | Result value, passed through |
| tgt_i | input | TGT_W (32) | Recovery address for a check |
| poison_o | output | NUM_REGS (16) | Token per register |
| wr_en_o | output | 1 | Write-back valid |
| wr_idx_o | output | IDX_W (4) | Write-back destination |
| wr_data_o | output | DATA_W (32) | Write-back value |
| wr_poison_o | output | 1 | Write-back token |
| exc_o | output | 1 | Non-deferred exception, one cycle |
| redir_o | output | 1 | Branch to recovery, one cycle |
| redir_tgt_o | output | TGT_W (32) | Recovery address |

## Verification
The bench uses the default build of 16 registers with 32-bit data and target words. With only 16 registers, a random stream of a few hundred descriptors reuses each index often. This produces long taint chains, two-source cases where both sources are marked, checks that land on both clean and marked registers, and frequent hits on register 0. Directed steps come first and cover the single-source, ignored-second-source and back-to-back redirect cases before the random phase.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_ALU  = 3'd1,
    OP_LD   = 3'd2,
    OP_LDS  = 3'd3,
    OP_CHK  = 3'd4
  } op_e;

  typedef struct packed {
    logic we;
    logic wpoison;
    logic exc;
    logic chk_hit;
  } issue_t;
endpackage

// File: rtl/dpt_issue.sv
module dpt_issue
  import dpt_pkg::*;
(
  input  logic       valid_i,
  input  logic [2:0] op_i,
  input  logic       src1_p_i,
  input  logic       src2_p_i,
  input  logic       use_rs2_i,
  input  logic       fault_i,
  output issue_t     iss_o
);
  logic taint;
  assign taint = src1_p_i | (use_rs2_i & src2_p_i);

  always_comb begin
    iss_o = '0;
    if (valid_i) begin
      unique case (op_i)
        OP_ALU, OP_LD: begin
          if (taint) begin
            iss_o.we      = 1'b1;
            iss_o.wpoison = 1'b1;
          end else if (fault_i) begin
            iss_o.exc = 1'b1;
          end else begin
            iss_o.we = 1'b1;
          end
        end
        OP_LDS: begin
          iss_o.we      = 1'b1;
          iss_o.wpoison = taint | fault_i;
        end
        OP_CHK:  iss_o.chk_hit = src1_p_i;
        default: iss_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/dpt_poison_file.sv
module dpt_poison_file #(
  parameter int NUM_REGS = 16,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [IDX_W-1:0]    widx_i,
  input  logic                wval_i,
  input  logic [IDX_W-1:0]    ridx1_i,
  input  logic [IDX_W-1:0]    ridx2_i,
  output logic                rval1_o,
  output logic                rval2_o,
  output logic [NUM_REGS-1:0] state_o
);
  logic [NUM_REGS-1:0] tok_q;

  assign tok_q[0] = 1'b0;  // hard-wired clean

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_tok
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                tok_q[g] <= 1'b0;
      else if (we_i && widx_i == IDX_W'(g))        tok_q[g] <= wval_i;
    end
  end

  assign rval1_o = tok_q[ridx1_i];
  assign rval2_o = tok_q[ridx2_i];
  assign state_o = tok_q;

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && widx_i != '0) |=> state_o[$past(widx_i)] == $past(wval_i)); // R9
endmodule

// File: rtl/dpt_result_reg.sv
module dpt_result_reg
  import dpt_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32,
  parameter int TGT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  issue_t            iss_i,
  input  logic [IDX_W-1:0]  rd_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [TGT_W-1:0]  tgt_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_poison_o,
  output logic              exc_o,
  output logic              redir_o,
  output logic [TGT_W-1:0]  redir_tgt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o     <= 1'b0;
      wr_idx_o    <= '0;
      wr_data_o   <= '0;
      wr_poison_o <= 1'b0;
      exc_o       <= 1'b0;
      redir_o     <= 1'b0;
      redir_tgt_o <= '0;
    end else begin
      wr_en_o     <= iss_i.we;
      wr_idx_o    <= iss_i.we ? rd_i : '0;
      wr_data_o   <= iss_i.we ? data_i : '0;
      wr_poison_o <= iss_i.we & iss_i.wpoison & (rd_i != '0);
      exc_o       <= iss_i.exc;
      redir_o     <= iss_i.chk_hit;
      redir_tgt_o <= iss_i.chk_hit ? tgt_i : '0;
    end
  end

  AST_EXC_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> !wr_en_o); // R5
  AST_TGT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !redir_o |-> redir_tgt_o == '0); // R7
endmodule

// File: rtl/deferred_poison_tracker.sv
module deferred_poison_tracker
  import dpt_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  parameter int TGT_W    = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [2:0]          op_i,
  input  logic [IDX_W-1:0]    rs1_i,
  input  logic [IDX_W-1:0]    rs2_i,
  input  logic                use_rs2_i,
  input  logic [IDX_W-1:0]    rd_i,
  input  logic                fault_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic [TGT_W-1:0]    tgt_i,
  output logic [NUM_REGS-1:0] poison_o,
  output logic                wr_en_o,
  output logic [IDX_W-1:0]    wr_idx_o,
  output logic [DATA_W-1:0]   wr_data_o,
  output logic                wr_poison_o,
  output logic                exc_o,
  output logic                redir_o,
  output logic [TGT_W-1:0]    redir_tgt_o
);
  logic   p1, p2;
  issue_t iss;

  dpt_poison_file #(.NUM_REGS(NUM_REGS)) u_pf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (iss.we),
    .widx_i  (rd_i),
    .wval_i  (iss.wpoison),
    .ridx1_i (rs1_i),
    .ridx2_i (rs2_i),
    .rval1_o (p1),
    .rval2_o (p2),
    .state_o (poison_o)
  );

  dpt_issue u_iss (
    .valid_i   (valid_i),
    .op_i      (op_i),
    .src1_p_i  (p1),
    .src2_p_i  (p2),
    .use_rs2_i (use_rs2_i),
    .fault_i   (fault_i),
    .iss_o     (iss)
  );

  dpt_result_reg #(.IDX_W(IDX_W), .DATA_W(DATA_W), .TGT_W(TGT_W)) u_res (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .iss_i       (iss),
    .rd_i        (rd_i),
    .data_i      (data_i),
    .tgt_i       (tgt_i),
    .wr_en_o     (wr_en_o),
    .wr_idx_o    (wr_idx_o),
    .wr_data_o   (wr_data_o),
    .wr_poison_o (wr_poison_o),
    .exc_o       (exc_o),
    .redir_o     (redir_o),
    .redir_tgt_o (redir_tgt_o)
  );

  AST_LDS_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd3) |=> !exc_o); // R2
  AST_LDS_FAULT_MARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd3 && fault_i && rd_i != '0) |=> poison_o[$past(rd_i)]); // R2
  AST_TAINT_FLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd1 && rd_i != '0 && (poison_o[rs1_i] || (use_rs2_i && poison_o[rs2_i])))
      |=> (poison_o[$past(rd_i)] && !exc_o)); // R4
  AST_REDIR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_o |-> $past(valid_i && op_i == 3'd4 && poison_o[rs1_i])); // R7
  AST_R0_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_idx_o == '0) |-> !wr_poison_o); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(poison_o) && !redir_o && !exc_o && !wr_en_o)); // R11
endmodule

// File: tb/deferred_poison_tracker_tb_top.sv
module deferred_poison_tracker_tb_top;
  localparam int NR = 16;
  localparam int IW = 4;
  localparam int DW = 32;
  localparam int TW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic [2:0]    op = '0;
  logic [IW-1:0] rs1 = '0, rs2 = '0, rd = '0;
  logic          use2 = 1'b0, fault = 1'b0;
  logic [DW-1:0] data = '0;
  logic [TW-1:0] tgt = '0;
  logic [NR-1:0] poison;
  logic          wr_en, wr_poison, exc, redir;
  logic [IW-1:0] wr_idx;
  logic [DW-1:0] wr_data;
  logic [TW-1:0] redir_tgt;

  int  vectors = 0;
  int  miscompares = 0;
  bit  done = 0;
  bit  model_p[NR];

  always #5 clk = ~clk;

  deferred_poison_tracker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .rs1_i(rs1), .rs2_i(rs2),
    .use_rs2_i(use2), .rd_i(rd), .fault_i(fault), .data_i(data), .tgt_i(tgt),
    .poison_o(poison), .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .wr_poison_o(wr_poison), .exc_o(exc), .redir_o(redir), .redir_tgt_o(redir_tgt)
  );

  function automatic logic [NR-1:0] model_vec();
    logic [NR-1:0] v;
    for (int i = 0; i < NR; i++) v[i] = model_p[i];
    return v;
  endfunction

  task automatic cmp(string req, string what, logic [63:0] act, logic [63:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive at negedge, predict, compare after the next posedge.
  task automatic step(string req, bit v, int o, int s1, int s2, bit u2, int d, bit f,
                      logic [DW-1:0] dat, logic [TW-1:0] t);
    bit e_we = 0, e_wp = 0, e_exc = 0, e_red = 0, taint;
    valid = v; op = 3'(o); rs1 = IW'(s1); rs2 = IW'(s2); use2 = u2;
    rd = IW'(d); fault = f; data = dat; tgt = t;
    taint = model_p[s1] || (u2 && model_p[s2]);
    if (v) begin
      case (o)
        1, 2: if (taint) begin e_we = 1; e_wp = 1; end
              else if (f) e_exc = 1;
              else e_we = 1;
        3:    begin e_we = 1; e_wp = taint || f; end
        4:    e_red = model_p[s1];
        default: ;
      endcase
    end
    if (d == 0) e_wp = 0;                       // R8
    if (e_we && d != 0) model_p[d] = e_wp;
    @(posedge clk);
    #2;
    vectors++;
    cmp(req, "poison_o", 64'(poison), 64'(model_vec()));
    cmp(req, "exc_o", 64'(exc), 64'(e_exc));
    cmp(req, "redir_o", 64'(redir), 64'(e_red));
    cmp(req, "redir_tgt_o", 64'(redir_tgt), e_red ? 64'(t) : 64'(0));
    cmp(req, "wr_en_o", 64'(wr_en), 64'(e_we));
    if (e_we) begin                              // R9
      cmp(req, "wr_idx_o", 64'(wr_idx), 64'(d));
      cmp(req, "wr_data_o", 64'(wr_data), 64'(dat));
      cmp(req, "wr_poison_o", 64'(wr_poison), 64'(e_wp));
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NR; i++) model_p[i] = 0;
    repeat (3) @(negedge clk);
    vectors++;                                   // R1 during reset
    cmp("R1", "poison_o", 64'(poison), 64'(0));
    cmp("R1", "outs", 64'({exc, redir, wr_en}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R2", 1, 3, 1, 0, 0, 3, 1, 32'hA3, 0);         // spec load faults -> r3 marked
    step("R4", 1, 1, 3, 4, 1, 5, 1, 32'hB5, 0);         // r5 = r3 op r4, own fault dropped
    step("R10", 1, 1, 1, 3, 0, 6, 0, 32'hC6, 0);        // rs2=r3 ignored
    step("R6", 1, 4, 6, 0, 0, 0, 0, 0, 32'h1111);       // check clean
    step("R7", 1, 4, 5, 0, 0, 0, 0, 0, 32'h1234);       // check marked
    step("R7", 1, 4, 3, 0, 0, 0, 0, 0, 32'h5678);       // back-to-back redirect
    step("R7", 1, 0, 0, 0, 0, 0, 0, 0, 32'h9999);       // pulse ends
    step("R4", 1, 1, 3, 5, 1, 7, 0, 32'hD7, 0);         // both sources marked
    step("R8", 1, 3, 1, 0, 0, 0, 1, 32'hE0, 0);         // r0 stays clean
    step("R5", 1, 2, 1, 0, 0, 3, 0, 32'hF3, 0);         // plain load clears r3
    step("R2", 1, 3, 2, 0, 0, 8, 1, 32'h18, 0);
    step("R5", 1, 1, 1, 2, 1, 8, 1, 32'h28, 0);         // clean ALU fault: exc, r8 kept
    step("R5", 1, 2, 1, 0, 0, 9, 1, 32'h39, 0);         // load fault: exc
    step("R2", 1, 3, 1, 0, 0, 9, 1, 32'h49, 0);
    step("R3", 1, 3, 1, 0, 0, 9, 0, 32'h59, 0);         // clean spec load clears r9
    step("R11", 0, 3, 1, 0, 0, 10, 1, 32'h6A, 32'h77);  // invalid
    step("R11", 1, 7, 8, 0, 0, 11, 1, 32'h7B, 32'h88);  // unused opcode
    step("R6", 1, 4, 6, 0, 0, 0, 0, 0, 32'h2222);
    for (int n = 0; n < 600; n++) begin
      int o;
      o = int'($urandom_range(0, 9));
      if (o > 4) o = (o > 7) ? 4 : 1;
      step("R4", $urandom_range(0, 7) != 0, o, int'($urandom_range(0, NR-1)),
           int'($urandom_range(0, NR-1)), 1'($urandom_range(0, 1)),
           int'($urandom_range(0, NR-1)), $urandom_range(0, 3) == 0,
           $urandom, $urandom);
    end
    finish_run();
  end
endmodule